// File: doc/BRIEF.md
# Banked Stack Pointer and Privilege Controller

This block keeps the execution context of a small 32-bit core: whether the core is running ordinary thread code or an exception handler, whether thread code is privileged, and which of two stack pointer registers is live. A kernel stack pointer serves handlers and boot code. A task stack pointer may serve thread code when the stored mode configuration asks for it. The decode stage and the exception sequencer drive strobes and write ports into the block. The block answers with the live stack pointer, the mode, the privilege level and the stored two-bit mode configuration.

Two small address services sit beside the state. The first gives the value that an instruction reading the program counter must see, which is the current instruction address advanced by four. The second checks a proposed branch target. The core uses a compact instruction encoding only, and every branch target must have its low bit set. A target with the low bit clear is flagged as a fault. A legal target is returned with that bit removed.

The kernel stack pointer is loaded from a boot word in the first cycle after reset is released. After that the block only tracks state and selects registers. It does no instruction decode, no frame stacking and no interrupt arbitration.

Top module: `bank_sp_priv`

## Requirements
- R1: While reset is high and on the cycle it is released, the block shows thread mode (`handler_o`=0), privileged (`priv_o`=1), `cfg_o`=2'b00, kernel stack live (`sp_sel_o`=0) and `sp_o`=0.
- R2: On the first rising edge with reset low, the kernel stack pointer loads `boot_sp_i` with bits [1:0] forced to 0. This load wins over a stack write in the same cycle. `boot_sp_i` has no effect at any later edge.
- R3: The task stack pointer is live (`sp_sel_o`=1) only in thread mode with `cfg_o[1]`=1. In handler mode the kernel stack pointer is always live, even when a handler has set `cfg_o[1]`.
- R4: A stack write (`sp_we_i`) stores `sp_wdata_i` with bits [1:0] cleared into the live stack pointer only. The other stack pointer keeps its value, and `sp_o` reads bits [1:0] as 0.
- R5: `priv_o` is 1 in handler mode. In thread mode it is the inverse of `cfg_o[0]`.
- R6: A configuration write (`cfg_we_i`) replaces both bits of `cfg_o` at the next edge if the block was privileged in that cycle. From unprivileged thread mode the write has no effect, so thread code can drop privilege but never raise it again.
- R7: Exception entry (`exc_enter_i`) puts the block in handler mode at the next edge and leaves the stored configuration bits untouched. If entry and return arrive in the same cycle, entry wins.
- R8: Exception return with code `exc_ret_code_i` selects thread mode when bit 0 is 1 and handler mode when bit 0 is 0. It loads code bit 1 into `cfg_o[1]` in the same edge, and this overrides a concurrent configuration write of that bit.
- R9: `pc_rd_o` equals `pc_i` + 4, modulo 2^32, with no delay.
- R10: When `br_valid_i` is 1 and `br_target_i[0]` is 0, `br_fault_o` is 1. Otherwise it is 0. `br_dest_o` is always `br_target_i` with bit 0 cleared.
- R11: A stack write in the same cycle as a mode change goes to the stack pointer that was live before the edge. `sp_o` after the edge shows the pointer selected by the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_sp_i | input | 32 | Boot word for the kernel stack pointer |
| exc_enter_i | input | 1 | Exception entry strobe |
| exc_return_i | input | 1 | Exception return strobe |
| exc_ret_code_i | input | 2 | Return code: bit 0 = target thread, bit 1 = task stack |
| cfg_we_i | input | 1 | Mode configuration write strobe |
| cfg_wdata_i | input | 2 | New configuration: bit 0 = unprivileged, bit 1 = task stack |
| sp_we_i | input | 1 | Live stack pointer write strobe |
| sp_wdata_i | input | 32 | Stack pointer write data |
| pc_i | input | 32 | Address of the current instruction |
| br_valid_i | input | 1 | Branch target present |
| br_target_i | input | 32 | Proposed branch target |
| sp_o | output | 32 | Live stack pointer |
| sp_sel_o | output | 1 | 1 when the task stack pointer is live |
| handler_o | output | 1 | 1 in handler mode |
| priv_o | output | 1 | 1 when privileged |
| cfg_o | output | 2 | Stored mode configuration |
| pc_rd_o | output | 32 | Program counter value seen by a read |
| br_dest_o | output | 32 | Branch destination with bit 0 cleared |
| br_fault_o | output | 1 | Illegal branch target flag |

## Verification
The risky overlap is a stack write landing in the same cycle as exception entry or return. Here the bank must write the pointer selected by the old mode, while `sp_o` at the next edge must show the pointer chosen by the new mode. A long pseudo-random stream drives entry, return, configuration writes and stack writes with independent odds, so the four overlap in many combinations. A directed sequence also writes the task stack while entry fires and later returns to it. After every edge, a bench-side model built from the requirements predicts both stack pointers, the mode and the configuration, and all visible outputs are compared with that prediction.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int ADDR_W_DEF = 32;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } mode_e;

    // bit 1: task stack requested, bit 0: thread drops privilege
    typedef struct packed {
        logic task_sp;
        logic unpriv;
    } cfg_t;

    typedef struct packed {
        mode_e mode;
        logic  task_sp;
    } ret_t;

    function automatic ret_t decode_ret(input logic [1:0] code);
        ret_t r;
        r.mode    = code[0] ? MODE_THREAD : MODE_HANDLER;
        r.task_sp = code[1];
        return r;
    endfunction

    function automatic logic priv_of(input mode_e m, input cfg_t c);
        return (m == MODE_HANDLER) || !c.unpriv;
    endfunction

endpackage

// File: rtl/bsp_mode_ctl.sv
module bsp_mode_ctl
    import bsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       exc_enter_i,
    input  logic       exc_return_i,
    input  logic [1:0] exc_ret_code_i,
    input  logic       cfg_we_i,
    input  logic [1:0] cfg_wdata_i,
    output mode_e      mode_o,
    output cfg_t       cfg_o,
    output logic       priv_o,
    output logic       task_active_o
);

    mode_e mode_q, mode_n;
    cfg_t  cfg_q, cfg_n;
    ret_t  ret_dec;

    assign ret_dec = decode_ret(exc_ret_code_i);

    always_comb begin
        mode_n = mode_q;
        cfg_n  = cfg_q;
        if (cfg_we_i && priv_of(mode_q, cfg_q)) begin
            cfg_n = cfg_t'(cfg_wdata_i);
        end
        if (exc_enter_i) begin
            mode_n = MODE_HANDLER;
        end else if (exc_return_i) begin
            mode_n        = ret_dec.mode;
            cfg_n.task_sp = ret_dec.task_sp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_THREAD;
            cfg_q  <= '0;
        end else begin
            mode_q <= mode_n;
            cfg_q  <= cfg_n;
        end
    end

    assign mode_o        = mode_q;
    assign cfg_o         = cfg_q;
    assign priv_o        = priv_of(mode_q, cfg_q);
    assign task_active_o = (mode_q == MODE_THREAD) && cfg_q.task_sp;

    // R7: entry always lands in handler mode
    p_enter_handler_r7: assert property (@(posedge clk) disable iff (rst)
        exc_enter_i |=> (mode_q == MODE_HANDLER));

    // R8: return without entry follows code bit 0
    p_return_mode_r8: assert property (@(posedge clk) disable iff (rst)
        (exc_return_i && !exc_enter_i) |=>
            (mode_q == ($past(exc_ret_code_i[0]) ? MODE_THREAD : MODE_HANDLER)));

    // R6: unprivileged thread cannot touch the configuration
    p_unpriv_locked_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_THREAD && cfg_q.unpriv && !exc_enter_i && !exc_return_i)
            |=> (cfg_q == $past(cfg_q)));

endmodule

// File: rtl/bsp_sp_bank.sv
module bsp_sp_bank #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] boot_word_i,
    input  logic          task_active_i,
    input  logic          sp_we_i,
    input  logic [AW-1:0] sp_wdata_i,
    output logic [AW-1:0] sp_o
);

    localparam logic [AW-1:0] ALIGN_MASK = ~{{(AW-2){1'b0}}, 2'b11};

    logic          boot_pend_q;
    logic [AW-1:0] kern_q;
    logic [AW-1:0] task_q;
    logic [AW-1:0] wr_aligned;
    logic [AW-1:0] boot_aligned;

    assign wr_aligned   = sp_wdata_i & ALIGN_MASK;
    assign boot_aligned = boot_word_i & ALIGN_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_pend_q <= 1'b1;
            kern_q      <= '0;
            task_q      <= '0;
        end else begin
            boot_pend_q <= 1'b0;
            if (boot_pend_q) begin
                kern_q <= boot_aligned;
            end else if (sp_we_i && !task_active_i) begin
                kern_q <= wr_aligned;
            end
            if (sp_we_i && task_active_i && !boot_pend_q) begin
                task_q <= wr_aligned;
            end
        end
    end

    assign sp_o = task_active_i ? task_q : kern_q;

    // R2: boot word captured on the first edge after reset
    p_boot_load_r2: assert property (@(posedge clk) disable iff (rst)
        boot_pend_q |=> (kern_q == ($past(boot_word_i) & ALIGN_MASK)));

    // R4: a write to the task stack leaves the kernel stack alone
    p_kern_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (sp_we_i && task_active_i && !boot_pend_q) |=> (kern_q == $past(kern_q)));

endmodule

// File: rtl/bsp_pc_view.sv
module bsp_pc_view #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc_i,
    input  logic          br_valid_i,
    input  logic [AW-1:0] br_target_i,
    output logic [AW-1:0] pc_rd_o,
    output logic [AW-1:0] br_dest_o,
    output logic          br_fault_o
);

    localparam logic [AW-1:0] PC_AHEAD = {{(AW-3){1'b0}}, 3'b100};
    localparam logic [AW-1:0] LSB_CLR  = ~{{(AW-1){1'b0}}, 1'b1};

    assign pc_rd_o    = pc_i + PC_AHEAD;
    assign br_dest_o  = br_target_i & LSB_CLR;
    assign br_fault_o = br_valid_i && !br_target_i[0];

endmodule

// File: rtl/bank_sp_priv.sv
module bank_sp_priv
    import bsp_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] boot_sp_i,
    input  logic              exc_enter_i,
    input  logic              exc_return_i,
    input  logic [1:0]        exc_ret_code_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_wdata_i,
    input  logic              sp_we_i,
    input  logic [ADDR_W-1:0] sp_wdata_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              br_valid_i,
    input  logic [ADDR_W-1:0] br_target_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic              sp_sel_o,
    output logic              handler_o,
    output logic              priv_o,
    output logic [1:0]        cfg_o,
    output logic [ADDR_W-1:0] pc_rd_o,
    output logic [ADDR_W-1:0] br_dest_o,
    output logic              br_fault_o
);

    mode_e mode;
    cfg_t  cfg;
    logic  task_active;

    bsp_mode_ctl u_mode (
        .clk            (clk),
        .rst            (rst),
        .exc_enter_i    (exc_enter_i),
        .exc_return_i   (exc_return_i),
        .exc_ret_code_i (exc_ret_code_i),
        .cfg_we_i       (cfg_we_i),
        .cfg_wdata_i    (cfg_wdata_i),
        .mode_o         (mode),
        .cfg_o          (cfg),
        .priv_o         (priv_o),
        .task_active_o  (task_active)
    );

    bsp_sp_bank #(.AW(ADDR_W)) u_bank (
        .clk           (clk),
        .rst           (rst),
        .boot_word_i   (boot_sp_i),
        .task_active_i (task_active),
        .sp_we_i       (sp_we_i),
        .sp_wdata_i    (sp_wdata_i),
        .sp_o          (sp_o)
    );

    bsp_pc_view #(.AW(ADDR_W)) u_pc (
        .pc_i        (pc_i),
        .br_valid_i  (br_valid_i),
        .br_target_i (br_target_i),
        .pc_rd_o     (pc_rd_o),
        .br_dest_o   (br_dest_o),
        .br_fault_o  (br_fault_o)
    );

    assign sp_sel_o  = task_active;
    assign handler_o = (mode == MODE_HANDLER);
    assign cfg_o     = cfg;

endmodule

// File: tb/tb_bank_sp_priv.sv
module tb_bank_sp_priv;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] boot_sp_i;
    logic        exc_enter_i, exc_return_i;
    logic [1:0]  exc_ret_code_i;
    logic        cfg_we_i;
    logic [1:0]  cfg_wdata_i;
    logic        sp_we_i;
    logic [31:0] sp_wdata_i;
    logic [31:0] pc_i;
    logic        br_valid_i;
    logic [31:0] br_target_i;
    logic [31:0] sp_o;
    logic        sp_sel_o, handler_o, priv_o;
    logic [1:0]  cfg_o;
    logic [31:0] pc_rd_o, br_dest_o;
    logic        br_fault_o;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    // reference state
    logic        m_hnd;
    logic [1:0]  m_cfg;
    logic [31:0] m_kern, m_task;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_sp_priv dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed ^ (seed >> 15);
    endfunction

    task automatic check_state();
        logic        exp_sel;
        logic [31:0] exp_sp;
        exp_sel = !m_hnd && m_cfg[1];
        exp_sp  = exp_sel ? m_task : m_kern;
        chk(sp_sel_o === exp_sel, "R3 live stack select", {31'b0, sp_sel_o}, {31'b0, exp_sel});
        chk(sp_o === exp_sp, "R4/R11 live stack value", sp_o, exp_sp);
        chk(handler_o === m_hnd, "R7/R8 mode", {31'b0, handler_o}, {31'b0, m_hnd});
        chk(priv_o === (m_hnd || !m_cfg[0]), "R5 privilege", {31'b0, priv_o}, {31'b0, (m_hnd || !m_cfg[0])});
        chk(cfg_o === m_cfg, "R6 configuration", {30'b0, cfg_o}, {30'b0, m_cfg});
    endtask

    // one edge of stimulus; model written from R4..R8 and R11
    task automatic step(input logic en, input logic rt, input logic [1:0] code,
                        input logic cw, input logic [1:0] cd,
                        input logic sw, input logic [31:0] sd);
        logic       live_task, priv_now;
        logic [1:0] ncfg;
        exc_enter_i = en; exc_return_i = rt; exc_ret_code_i = code;
        cfg_we_i = cw; cfg_wdata_i = cd; sp_we_i = sw; sp_wdata_i = sd;
        live_task = !m_hnd && m_cfg[1];
        priv_now  = m_hnd || !m_cfg[0];
        if (sw) begin
            if (live_task) m_task = sd & 32'hFFFF_FFFC;
            else           m_kern = sd & 32'hFFFF_FFFC;
        end
        ncfg = m_cfg;
        if (cw && priv_now) ncfg = cd;
        if (en) m_hnd = 1'b1;
        else if (rt) begin
            m_hnd   = !code[0];
            ncfg[1] = code[1];
        end
        m_cfg = ncfg;
        @(posedge clk); #1;
        exc_enter_i = 0; exc_return_i = 0; cfg_we_i = 0; sp_we_i = 0;
        check_state();
    endtask

    initial begin : watchdog
        while (cycles < WATCHDOG && !done) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        rst = 1; boot_sp_i = 32'hDEAD_BEE7;
        exc_enter_i = 0; exc_return_i = 0; exc_ret_code_i = 0;
        cfg_we_i = 0; cfg_wdata_i = 0; sp_we_i = 0; sp_wdata_i = 0;
        pc_i = 0; br_valid_i = 0; br_target_i = 0;
        m_hnd = 0; m_cfg = 0; m_kern = 0; m_task = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check_state();
        chk(sp_o === 32'h0, "R1 reset stack", sp_o, 32'h0);
        rst = 0;
        // R2: boot load wins over a simultaneous write
        sp_we_i = 1; sp_wdata_i = 32'h5555_5555;
        @(posedge clk); #1;
        sp_we_i = 0;
        m_kern = 32'hDEAD_BEE4;
        chk(sp_o === 32'hDEAD_BEE4, "R2 boot word loaded", sp_o, 32'hDEAD_BEE4);
        chk(handler_o === 1'b0 && priv_o === 1'b1, "R1 state after release", {30'b0, handler_o, priv_o}, 32'h1);
        boot_sp_i = 32'h0000_1230;
        repeat (2) @(posedge clk); #1;
        chk(sp_o === 32'hDEAD_BEE4, "R2 boot word ignored later", sp_o, 32'hDEAD_BEE4);

        // R11 directed: select task stack, write it during entry
        step(0, 0, 2'b00, 1, 2'b10, 0, 32'h0);
        step(1, 0, 2'b00, 0, 2'b00, 1, 32'h0000_0103);
        chk(sp_o === m_kern, "R11 kernel live after entry", sp_o, m_kern);
        step(0, 1, 2'b11, 0, 2'b00, 0, 32'h0);
        chk(sp_o === 32'h0000_0100, "R11 write reached old stack", sp_o, 32'h0000_0100);
        // R3: handler sets task bit but kernel stays live
        step(1, 0, 2'b00, 0, 2'b00, 0, 32'h0);
        step(0, 0, 2'b00, 1, 2'b10, 0, 32'h0);
        chk(sp_sel_o === 1'b0, "R3 handler keeps kernel stack", {31'b0, sp_sel_o}, 32'h0);
        // R6: drop privilege then try to regain it
        step(0, 1, 2'b01, 0, 2'b00, 0, 32'h0);
        step(0, 0, 2'b00, 1, 2'b01, 0, 32'h0);
        step(0, 0, 2'b00, 1, 2'b00, 0, 32'h0);
        chk(priv_o === 1'b0, "R6 privilege not regained by write", {31'b0, priv_o}, 32'h0);
        // R7: entry beats return
        step(1, 1, 2'b01, 0, 2'b00, 0, 32'h0);
        chk(handler_o === 1'b1, "R7 entry wins over return", {31'b0, handler_o}, 32'h1);

        // mixed stream
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = nxt_rand();
            step(r[2:0] == 3'd0, r[5:3] == 3'd0, r[7:6],
                 r[9:8] == 2'd0, r[11:10], r[12], nxt_rand());
        end

        // R9: program counter view
        for (int i = 0; i < 64; i++) begin
            logic [31:0] p;
            p = (i == 0) ? 32'hFFFF_FFFE : (i == 1) ? 32'hFFFF_FFFC : nxt_rand() & 32'hFFFF_FFFE;
            pc_i = p; #1;
            chk(pc_rd_o === p + 32'd4, "R9 pc read value", pc_rd_o, p + 32'd4);
        end
        // R10: branch target check, sweep low bits and valid
        for (int i = 0; i < 128; i++) begin
            logic [31:0] t;
            logic        v;
            t = {nxt_rand()[31:6], i[5:0]};
            v = i[6];
            br_target_i = t; br_valid_i = v; #1;
            chk(br_fault_o === (v && !t[0]), "R10 branch fault", {31'b0, br_fault_o}, {31'b0, (v && !t[0])});
            chk(br_dest_o === (t & 32'hFFFF_FFFE), "R10 branch destination", br_dest_o, t & 32'hFFFF_FFFE);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule